// File: doc/BRIEF.md
# Memory-to-Memory Byte Copy Engine

This block copies a run of bytes from one memory region to another, one byte at a time. Two channel register sets drive the copy. The first set supplies the source address. The second set supplies the destination address and the byte count that ends the copy. Each byte is fetched over a request/acknowledge read port into a one-byte holding register. In a separate, later bus phase it is written from that register to the destination over a request/acknowledge write port.

A host writes the start addresses, the count and a mode word through a small write-only register port, then writes the start register. Each address steps up or down after every byte, and the source address can be frozen so that a single byte value fills the destination range. When the count runs out, a one-cycle terminal-count pulse fires and a level done flag is raised. If automatic reload is enabled, the working addresses and count are restored from the values the host programmed, so the same copy can be started again without reprogramming.

Top module: `mem_copy_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_req`, `wr_req`, `done` and `tc` are all low.
- R2: A host write (`host_wr` high) selects a register by `host_addr`: 0 = source start address, 1 = destination start address, 2 = byte count, 3 = mode word, 4 = start (its data is ignored). Mode bit 0 makes the source step down, bit 1 makes the destination step down, bit 2 freezes the source address, and bit 3 enables automatic reload. Writing an address or the count sets both its stored start value and its working value. Register writes take effect only while the engine is idle.
- R3: Each byte is moved in two phases. A read request at the source address is held with a stable address until `rd_ack`, and `rd_data` is captured into an 8-bit holding register on that acknowledge. At least one cycle later, a write request carries that byte to the destination address, with address and data held stable until `wr_ack`. `rd_req` and `wr_req` are never high together.
- R4: The working count drops by one on every acknowledged write. The copy ends after the write that brings the count to zero, so a count of N gives exactly N reads and N writes.
- R5: At the end of a copy, `tc` is high for exactly one cycle and `done` goes high and stays high. A start with a count of zero performs no memory access and still gives one `tc` pulse and `done`.
- R6: After each byte, the source and destination addresses each step by one in their own programmed direction, wrapping modulo 2^AW.
- R7: With the source address frozen, every byte is read from the source start address.
- R8: The next read request is issued only after the previous write has been acknowledged, so a byte written earlier in the same copy is seen by any later read of that address.
- R9: With automatic reload enabled, the working addresses and count are restored to their start values when a copy ends, so a second start repeats the copy. Without it, the working count stays at zero, and a second start performs no access but still completes with `tc` and `done`.
- R10: A start command is ignored while a copy is in progress. `done` is cleared in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register select |
| host_wdata | input | HW = max(AW, CW) | Host write data |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read address (source) |
| rd_ack | input | 1 | Memory read acknowledge, `rd_data` valid |
| rd_data | input | 8 | Memory read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | AW | Memory write address (destination) |
| wr_data | output | 8 | Memory write data from the holding register |
| wr_ack | input | 1 | Memory write acknowledge |
| done | output | 1 | Copy finished flag |
| tc | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench builds the engine with AW = 8 and CW = 8, so a 256-byte memory model covers the whole address space. After every copy the entire memory is compared against a reference computed in order, byte by byte. With that width, address wrap at both ends is reachable, as are overlapping source and destination ranges where ordering matters. Every combination of the two direction bits and the freeze bit is swept over counts of 0, 1, 2, 5 and 17. Directed runs cover reload, non-reload restart, and a start issued mid-copy.

// File: rtl/mce_pkg.sv
package mce_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam int unsigned OFS_SRC  = 0;
  localparam int unsigned OFS_DST  = 1;
  localparam int unsigned OFS_CNT  = 2;
  localparam int unsigned OFS_MODE = 3;
  localparam int unsigned OFS_GO   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_HOLD,
    ST_WRITE,
    ST_DONE
  } mce_state_e;

  typedef struct packed {
    logic auto_rl;
    logic src_fix;
    logic dst_dec;
    logic src_dec;
  } mce_mode_t;

endpackage

// File: rtl/mce_chan.sv
module mce_chan #(
  parameter int AW      = 16,
  parameter int CW      = 16,
  parameter bit HAS_CNT = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] addr_val,
  input  logic [CW-1:0] cnt_val,
  input  logic          step,
  input  logic          dec,
  input  logic          freeze,
  input  logic          reload,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          cnt_zero,
  output logic          cnt_one
);

  logic [AW-1:0] base_addr_q;
  logic [AW-1:0] cur_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
    end else if (ld_addr) begin
      base_addr_q <= addr_val;
      cur_addr_q  <= addr_val;
    end else if (reload) begin
      cur_addr_q  <= base_addr_q;
    end else if (step && !freeze) begin
      cur_addr_q  <= dec ? cur_addr_q - 1'b1 : cur_addr_q + 1'b1;
    end
  end

  assign cur_addr = cur_addr_q;

  // R7
  frozen_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (step && freeze && !ld_addr && !reload) |=> $stable(cur_addr_q));

  generate
    if (HAS_CNT) begin : g_cnt
      logic [CW-1:0] base_cnt_q;
      logic [CW-1:0] cur_cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          base_cnt_q <= '0;
          cur_cnt_q  <= '0;
        end else if (ld_cnt) begin
          base_cnt_q <= cnt_val;
          cur_cnt_q  <= cnt_val;
        end else if (reload) begin
          cur_cnt_q  <= base_cnt_q;
        end else if (step) begin
          cur_cnt_q  <= cur_cnt_q - 1'b1;
        end
      end

      assign cur_cnt  = cur_cnt_q;
      assign cnt_zero = (cur_cnt_q == '0);
      assign cnt_one  = (cur_cnt_q == CW'(1));

      // R4
      cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_cnt && !reload) |=> (cur_cnt_q == $past(cur_cnt_q) - 1'b1));
    end else begin : g_nocnt
      logic cnt_unused;
      assign cnt_unused = ^{ld_cnt, cnt_val};
      assign cur_cnt  = '0;
      assign cnt_zero = 1'b1;
      assign cnt_one  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/mce_seq.sv
module mce_seq
  import mce_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cnt_zero,
  input  logic              cnt_one,
  input  logic              rd_ack,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              wr_ack,
  output logic              rd_req,
  output logic              wr_req,
  output logic [BYTE_W-1:0] wr_data,
  output logic              done,
  output logic              tc,
  output logic              step,
  output logic              finish,
  output logic              idle
);

  mce_state_e        st;
  logic              rd_req_q;
  logic              wr_req_q;
  logic [BYTE_W-1:0] hold_q;
  logic              done_q;
  logic              tc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      rd_req_q <= 1'b0;
      wr_req_q <= 1'b0;
      hold_q   <= '0;
      done_q   <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            done_q <= 1'b0;
            if (cnt_zero) begin
              st <= ST_DONE;
            end else begin
              st       <= ST_READ;
              rd_req_q <= 1'b1;
            end
          end
        end
        ST_READ: begin
          if (rd_ack) begin
            hold_q   <= rd_data;
            rd_req_q <= 1'b0;
            st       <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          wr_req_q <= 1'b1;
          st       <= ST_WRITE;
        end
        ST_WRITE: begin
          if (wr_ack) begin
            wr_req_q <= 1'b0;
            if (cnt_one) begin
              st <= ST_DONE;
            end else begin
              st       <= ST_READ;
              rd_req_q <= 1'b1;
            end
          end
        end
        ST_DONE: begin
          done_q <= 1'b1;
          tc_q   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_req  = rd_req_q;
  assign wr_req  = wr_req_q;
  assign wr_data = hold_q;
  assign done    = done_q;
  assign tc      = tc_q;
  assign step    = (st == ST_WRITE) && wr_ack;
  assign finish  = (st == ST_DONE);
  assign idle    = (st == ST_IDLE);

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_q && wr_req_q));

  // R3
  hold_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_q && rd_ack) |=> (hold_q == $past(rd_data)));

  // R3
  wr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req_q && !wr_ack) |=> (wr_req_q && $stable(hold_q)));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_q && !rd_ack) |=> rd_req_q);

  // R8
  rd_after_wack_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req_q && !wr_ack) |=> !rd_req_q);

  // R5
  tc_single_chk: assert property (@(posedge clk) disable iff (rst)
    tc_q |=> !tc_q);

  // R5
  tc_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tc_q) |-> done_q);

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && start) |=> !done_q);

endmodule

// File: rtl/mem_copy_engine.sv
module mem_copy_engine
  import mce_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int HW = (AW > CW) ? AW : CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [HW-1:0]     host_wdata,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic              tc
);

  localparam int NCH = 2;

  mce_mode_t mode_q;
  logic      idle;
  logic      step;
  logic      finish;
  logic      start;
  logic      wr_src, wr_dst, wr_cnt, wr_mode;

  logic [AW-1:0] ch_addr [NCH];
  logic [CW-1:0] ch_cnt  [NCH];
  logic          ch_zero [NCH];
  logic          ch_one  [NCH];

  logic host_unused;
  logic chan_unused;
  assign host_unused = ^host_wdata;
  assign chan_unused = ^{ch_cnt[0], ch_cnt[1], ch_zero[0], ch_one[0]};

  assign start   = host_wr && (host_addr == 3'(OFS_GO));
  assign wr_src  = host_wr && idle && (host_addr == 3'(OFS_SRC));
  assign wr_dst  = host_wr && idle && (host_addr == 3'(OFS_DST));
  assign wr_cnt  = host_wr && idle && (host_addr == 3'(OFS_CNT));
  assign wr_mode = host_wr && idle && (host_addr == 3'(OFS_MODE));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= mce_mode_t'(host_wdata[3:0]);
    end
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam bit IS_SRC = (i == 0);
      mce_chan #(
        .AW      (AW),
        .CW      (CW),
        .HAS_CNT (!IS_SRC)
      ) u_chan (
        .clk      (clk),
        .rst      (rst),
        .ld_addr  (IS_SRC ? wr_src : wr_dst),
        .ld_cnt   (IS_SRC ? 1'b0 : wr_cnt),
        .addr_val (host_wdata[AW-1:0]),
        .cnt_val  (host_wdata[CW-1:0]),
        .step     (step),
        .dec      (IS_SRC ? mode_q.src_dec : mode_q.dst_dec),
        .freeze   (IS_SRC ? mode_q.src_fix : 1'b0),
        .reload   (finish && mode_q.auto_rl),
        .cur_addr (ch_addr[i]),
        .cur_cnt  (ch_cnt[i]),
        .cnt_zero (ch_zero[i]),
        .cnt_one  (ch_one[i])
      );
    end
  endgenerate

  mce_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cnt_zero (ch_zero[1]),
    .cnt_one  (ch_one[1]),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data),
    .wr_ack   (wr_ack),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .wr_data  (wr_data),
    .done     (done),
    .tc       (tc),
    .step     (step),
    .finish   (finish),
    .idle     (idle)
  );

  assign rd_addr = ch_addr[0];
  assign wr_addr = ch_addr[1];

  // R3
  rd_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> $stable(rd_addr));

  // R3
  wr_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> $stable(wr_addr));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && start) |=> !done);

endmodule

// File: tb/sim_mem_copy_engine.sv
module sim_mem_copy_engine;

  localparam int AW = 8;
  localparam int CW = 8;
  localparam int HW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic [2:0]    host_addr = '0;
  logic [HW-1:0] host_wdata = '0;
  logic          rd_req, wr_req, done, tc;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;
  logic          rd_ack, wr_ack;

  always #10 clk = ~clk;

  mem_copy_engine #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .done(done), .tc(tc)
  );

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  int n_rd, n_wr, n_tc;
  bit clr = 1'b1;
  int total = 0;
  int bad = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      n_rd <= 0; n_wr <= 0; n_tc <= 0;
      rd_ack <= 1'b0; wr_ack <= 1'b0; rd_data <= '0;
    end else begin
      if (rd_req && !rd_ack) begin
        rd_ack <= 1'b1; rd_data <= mem[rd_addr]; n_rd <= n_rd + 1;
      end else rd_ack <= 1'b0;
      if (wr_req && !wr_ack) begin
        wr_ack <= 1'b1; mem[wr_addr] <= wr_data; n_wr <= n_wr + 1;
      end else wr_ack <= 1'b0;
      if (tc) n_tc <= n_tc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: host register write
  task automatic hw(input int a, input int v);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 3'(a); host_wdata = HW'(v);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bench_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic model(input int s, input int d, input int n, input int m);
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    for (int k = 0; k < n; k++) begin
      int sa, da;
      sa = m[2] ? s : (m[0] ? s - k : s + k);
      da = m[1] ? d - k : d + k;
      exp_mem[da & 255] = exp_mem[sa & 255];
    end
  endtask

  task automatic launch_wait(input bit poke);
    hw(4, 0);
    chk(done == 1'b0, "R10 done cleared", int'(done), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      hw(4, 0);
    end
    for (int t = 0; t < 4000 && !done; t++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare(input string tag, input int n);
    int mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, tag, mism, 0);
    chk(n_wr == n, "R4 writes", n_wr, n);
    chk(n_rd == n, "R3 reads", n_rd, n);
    chk(n_tc == 1, "R5 tc pulses", n_tc, 1);
    chk(done == 1'b1, "R5 done", int'(done), 1);
    chk(tc == 1'b0, "R5 tc low", int'(tc), 0);
  endtask

  task automatic run(input int s, input int d, input int n, input int m,
                     input bit poke, input string tag);
    bench_clear();
    hw(0, s); hw(1, d); hw(2, n); hw(3, m);
    model(s, d, n, m);
    launch_wait(poke);
    compare(tag, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(rd_req == 1'b0, "R1 rd_req", int'(rd_req), 0);
    chk(wr_req == 1'b0, "R1 wr_req", int'(wr_req), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(tc == 1'b0, "R1 tc", int'(tc), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!(rd_req || wr_req || done || tc), "R1 after reset", int'({rd_req, wr_req, done, tc}), 0);
    clr = 1'b0;

    // R6 R7: sweep directions, freeze, counts
    for (int m = 0; m < 8; m++) begin
      for (int j = 0; j < 5; j++) begin
        int n;
        n = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 2 : (j == 3) ? 5 : 17;
        run(8'h30, 8'hA0, n, m, 1'b0, m[2] ? "R7 memory" : "R6 memory");
      end
    end

    // R6 wrap with R8 overlap ordering
    run(8'hFE, 8'h02, 4, 4'b0010, 1'b0, "R8 wrap/overlap memory");
    run(8'h01, 8'hFD, 6, 4'b0001, 1'b0, "R6 wrap memory");

    // R10: start during copy ignored
    run(8'h30, 8'hA0, 8, 0, 1'b1, "R10 memory");

    // R9: automatic reload repeats copy
    run(8'h30, 8'hA0, 4, 4'b1000, 1'b0, "R9 first memory");
    bench_clear();
    model(8'h30, 8'hA0, 4, 4'b1000);
    launch_wait(1'b0);
    compare("R9 reload memory", 4);

    // R9: without reload restart does nothing
    run(8'h30, 8'hA0, 4, 4'b0000, 1'b0, "R9 first memory");
    bench_clear();
    model(8'h30, 8'hA0, 0, 0);
    launch_wait(1'b0);
    compare("R9 no-reload memory", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule